// File: doc/BRIEF.md
# SPI Flash Status and Identification Responder

This block is the command layer of a serial-flash slave. A separate bit shifter delivers each received byte with a one-cycle strobe and passes through the active-low chip-select. The block decodes the first byte of every select frame as an opcode and tracks the parameter bytes that follow. It presents the byte to be shifted out on the next transfer on `tx_byte`.

It holds an 8-bit status word. The word has a write enable latch, four protection bits, a continuous-program flag and a status-lock bit. Write-in-progress is taken live from an external `busy_in` line, which stands in for an internal program or erase engine. The block answers the status-read, JEDEC-style identification and legacy two-byte identification commands. The legacy command can return the identification bytes in either order. It also handles the latch set and clear commands and a guarded status-write command. The memory array and the bit-level shift logic are outside this block.

Top module: `spi_stat_id_resp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status_o[7:1]` is 0 and `tx_byte` is 0xFF. A frame in progress is abandoned, and the next selected byte is decoded as an opcode.
- R2: `status_o` bit 0 equals `busy_in` in the same cycle. Bit 1 is the write enable latch (WEL). Bits 5:2 are protection bits. Bit 6 is the continuous-program flag. Bit 7 is the status-lock bit.
- R3: The opcode 0x06 sets WEL and the opcode 0x04 clears it, visible on `status_o[1]` one cycle after the strobe. If a busy fall occurs in the same cycle, the opcode wins.
- R4: After the opcode 0x05, `tx_byte` equals the live `status_o` on every following byte until `cs_n` goes high.
- R5: After the opcode 0x9F, the next three transfers return, in order, the manufacturer ID, the memory type and the device ID. Every later transfer in that frame returns 0xFF.
- R6: The opcode 0x90 is followed by two dummy bytes and then a selector byte. A selector of 0x00 returns the manufacturer ID and then the device ID. Any other selector returns the device ID and then the manufacturer ID. After the two ID bytes the frame returns 0xFF.
- R7: The opcode 0x01 loads `status_o[7:2]` from bits 7:2 of the next byte, one cycle after its strobe, only while WEL is set. Bits 1:0 of that byte are ignored.
- R8: While the status-lock bit (bit 7) is set, a status write under R7 is blocked unless `wp_in` is high.
- R9: At the rising edge of `cs_n` that closes a frame whose opcode was 0x01, WEL is cleared, visible one cycle later. This applies whether or not the write took effect.
- R10: A falling edge of `busy_in` clears WEL one cycle later.
- R11: `tx_byte` is 0xFF while `cs_n` is high, during opcode and parameter bytes, and for the whole of a frame with an unsupported opcode.
- R12: Byte strobes that arrive while `cs_n` is high are ignored and change neither the status word nor the frame state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip-select from the shifter |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| busy_in | input | 1 | External write-operation busy flag |
| wp_in | input | 1 | Write-protect override; high permits a write to a locked status word |
| tx_byte | output | 8 | Byte to shift out on the next transfer |
| status_o | output | 8 | Current status word |

## Verification
Every response byte is due on the cycle after its strobe edge, because `tx_byte` is decoded from the frame state registered at that edge. The scoreboard pops one expected byte 1 ns after each selected strobe edge. Latch and status-field changes take one register stage after a strobe, a select rise or a busy fall, so the bench reads `status_o` at the following falling edge. Write-in-progress has no register in its path, and the status-stream checks raise and drop `busy_in` mid-frame to show that.

// File: rtl/spi_resp_pkg.sv
package spi_resp_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 2;

    localparam logic [BYTE_W-1:0] OP_LATCH_ON  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_LATCH_OFF = 8'h04;
    localparam logic [BYTE_W-1:0] OP_STAT_RD   = 8'h05;
    localparam logic [BYTE_W-1:0] OP_STAT_WR   = 8'h01;
    localparam logic [BYTE_W-1:0] OP_JID       = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_LEGACY_ID = 8'h90;
    localparam logic [BYTE_W-1:0] IDLE_BYTE    = 8'hFF;

    localparam int JID_LAST   = 2;
    localparam int DUMMY_LAST = 1;
    localparam int PAIR_LAST  = 1;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_STREAM,
        PH_JID,
        PH_DUMMY,
        PH_SELECT,
        PH_PAIR,
        PH_WRDATA,
        PH_QUIET
    } phase_e;

    typedef struct packed {
        logic              latch_on;
        logic              latch_off;
        logic              wr_fire;
        logic              frame_close;
        logic [BYTE_W-1:0] wr_data;
    } seq_ev_t;

    typedef struct packed {
        logic       lock;
        logic       cprog;
        logic [3:0] prot;
        logic       wel;
        logic       wip;
    } stat_t;

    function automatic logic [BYTE_W-1:0] pair_pick(
        input logic              mfr_first,
        input logic [IDX_W-1:0]  idx,
        input logic [BYTE_W-1:0] mfr,
        input logic [BYTE_W-1:0] dev
    );
        logic first_slot;
        first_slot = (idx == '0);
        return (first_slot == mfr_first) ? mfr : dev;
    endfunction

endpackage

// File: rtl/spi_resp_seq.sv
module spi_resp_seq
    import spi_resp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    output phase_e                phase,
    output logic [IDX_W-1:0]      idx,
    output logic                  mfr_first,
    output seq_ev_t               ev
);

    logic cs_q;
    logic wr_frame_q;
    logic strobe;
    logic cs_rise;

    assign strobe  = rx_valid && !cs_n;
    assign cs_rise = cs_n && !cs_q;

    always_comb begin
        ev             = '0;
        ev.wr_data     = rx_byte;
        ev.latch_on    = strobe && (phase == PH_OPCODE) && (rx_byte == OP_LATCH_ON);
        ev.latch_off   = strobe && (phase == PH_OPCODE) && (rx_byte == OP_LATCH_OFF);
        ev.wr_fire     = strobe && (phase == PH_WRDATA);
        ev.frame_close = cs_rise && wr_frame_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q       <= 1'b1;
            phase      <= PH_OPCODE;
            idx        <= '0;
            mfr_first  <= 1'b1;
            wr_frame_q <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                phase      <= PH_OPCODE;
                idx        <= '0;
                wr_frame_q <= 1'b0;
            end else if (rx_valid) begin
                case (phase)
                    PH_OPCODE: begin
                        idx <= '0;
                        case (rx_byte)
                            OP_STAT_RD:   phase <= PH_STREAM;
                            OP_JID:       phase <= PH_JID;
                            OP_LEGACY_ID: phase <= PH_DUMMY;
                            OP_STAT_WR: begin
                                phase      <= PH_WRDATA;
                                wr_frame_q <= 1'b1;
                            end
                            default:      phase <= PH_QUIET;
                        endcase
                    end
                    PH_JID: begin
                        if (idx == IDX_W'(JID_LAST)) phase <= PH_QUIET;
                        else                         idx   <= idx + 1'b1;
                    end
                    PH_DUMMY: begin
                        if (idx == IDX_W'(DUMMY_LAST)) begin
                            phase <= PH_SELECT;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    PH_SELECT: begin
                        mfr_first <= (rx_byte == 8'h00);
                        phase     <= PH_PAIR;
                        idx       <= '0;
                    end
                    PH_PAIR: begin
                        if (idx == IDX_W'(PAIR_LAST)) phase <= PH_QUIET;
                        else                          idx   <= idx + 1'b1;
                    end
                    PH_WRDATA: phase <= PH_QUIET;
                    default:   phase <= phase;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_resp_stat.sv
module spi_resp_stat
    import spi_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_in,
    input  logic              wp_in,
    input  seq_ev_t           ev,
    output logic [BYTE_W-1:0] status_o
);

    stat_t sreg;
    logic  busy_q;
    logic  busy_fall;
    logic  wr_ok;

    assign busy_fall = busy_q && !busy_in;
    assign wr_ok     = ev.wr_fire && sreg.wel && (!sreg.lock || wp_in);

    always_ff @(posedge clk) begin
        busy_q <= busy_in;
        if (rst) begin
            sreg.lock  <= 1'b0;
            sreg.cprog <= 1'b0;
            sreg.prot  <= '0;
            sreg.wel   <= 1'b0;
        end else begin
            if (wr_ok) begin
                sreg.lock  <= ev.wr_data[7];
                sreg.cprog <= ev.wr_data[6];
                sreg.prot  <= ev.wr_data[5:2];
            end
            if (ev.latch_on)
                sreg.wel <= 1'b1;
            else if (ev.latch_off || ev.frame_close || busy_fall)
                sreg.wel <= 1'b0;
        end
    end

    always_comb begin
        sreg.wip = busy_in;
    end

    assign status_o = sreg;

endmodule

// File: rtl/spi_resp_txsel.sv
module spi_resp_txsel
    import spi_resp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFR_ID   = 8'hC2,
    parameter logic [BYTE_W-1:0] MEM_TYPE = 8'h20,
    parameter logic [BYTE_W-1:0] DEV_ID   = 8'h15
) (
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  idx,
    input  logic              mfr_first,
    input  logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] tx_byte
);

    logic [BYTE_W-1:0] jid_tbl [JID_LAST+1];

    assign jid_tbl[0] = MFR_ID;
    assign jid_tbl[1] = MEM_TYPE;
    assign jid_tbl[2] = DEV_ID;

    always_comb begin
        case (phase)
            PH_STREAM: tx_byte = status;
            PH_JID:    tx_byte = (idx <= IDX_W'(JID_LAST)) ? jid_tbl[idx] : IDLE_BYTE;
            PH_PAIR:   tx_byte = pair_pick(mfr_first, idx, MFR_ID, DEV_ID);
            default:   tx_byte = IDLE_BYTE;
        endcase
    end

endmodule

// File: rtl/spi_stat_id_resp.sv
module spi_stat_id_resp
    import spi_resp_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_ID   = 8'h15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       busy_in,
    input  logic       wp_in,
    output logic [7:0] tx_byte,
    output logic [7:0] status_o
);

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             mfr_first;
    seq_ev_t          ev;
    logic             at_op;

    assign at_op = (phase == PH_OPCODE);

    spi_resp_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .phase     (phase),
        .idx       (idx),
        .mfr_first (mfr_first),
        .ev        (ev)
    );

    spi_resp_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .busy_in  (busy_in),
        .wp_in    (wp_in),
        .ev       (ev),
        .status_o (status_o)
    );

    spi_resp_txsel #(
        .MFR_ID   (MFR_ID),
        .MEM_TYPE (MEM_TYPE),
        .DEV_ID   (DEV_ID)
    ) u_tx (
        .phase     (phase),
        .idx       (idx),
        .mfr_first (mfr_first),
        .status    (status_o),
        .tx_byte   (tx_byte)
    );

endmodule

// File: rtl/spi_resp_chk.sv
module spi_resp_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       busy_in,
    input logic       wp_in,
    input logic [7:0] tx_byte,
    input logic [7:0] status_o,
    input logic       at_op
);

    logic op_strobe;
    assign op_strobe = rx_valid && !cs_n && at_op;

    // R3
    a_r3_latch_on: assert property (@(posedge clk) disable iff (rst)
        op_strobe && rx_byte == 8'h06 |=> status_o[1]);

    // R3
    a_r3_latch_off: assert property (@(posedge clk) disable iff (rst)
        op_strobe && rx_byte == 8'h04 |=> !status_o[1]);

    // R10
    a_r10_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_in) && !(op_strobe && rx_byte == 8'h06) |=> !status_o[1]);

    // R7
    a_r7_no_latch_no_write: assert property (@(posedge clk) disable iff (rst)
        !status_o[1] |=> $stable(status_o[7:2]));

    // R8
    a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
        status_o[7] && !wp_in |=> $stable(status_o[7:2]));

    // R12
    a_r12_deselected_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(status_o[7:2]));

    // R11
    a_r11_idle_ff: assert property (@(posedge clk) disable iff (rst)
        cs_n && $past(cs_n) |-> tx_byte == 8'hFF);

endmodule

bind spi_stat_id_resp spi_resp_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .busy_in  (busy_in),
    .wp_in    (wp_in),
    .tx_byte  (tx_byte),
    .status_o (status_o),
    .at_op    (at_op)
);

// File: tb/spi_stat_id_resp_tb_top.sv
`timescale 1ns/1ps
module spi_stat_id_resp_tb_top;

    localparam logic [7:0] T_MFR  = 8'hA5;
    localparam logic [7:0] T_TYPE = 8'h3C;
    localparam logic [7:0] T_DEV  = 8'h17;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       busy_in = 1'b0;
    logic       wp_in = 1'b0;
    logic [7:0] tx_byte;
    logic [7:0] status_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    spi_stat_id_resp #(
        .MFR_ID   (T_MFR),
        .MEM_TYPE (T_TYPE),
        .DEV_ID   (T_DEV)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .busy_in  (busy_in),
        .wp_in    (wp_in),
        .tx_byte  (tx_byte),
        .status_o (status_o)
    );

    // Monitor: each selected strobe edge yields one response byte 1 ns later.
    always @(posedge clk) begin
        if (rx_valid && !cs_n && !rst) begin
            #1;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected response %02h (expected none)", tx_byte);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (tx_byte !== e.val) begin
                    fails++;
                    $display("FAIL %s: tx_byte actual %02h expected %02h", e.tag, tx_byte, e.val);
                end
            end
        end
    end

    task automatic xfer(input logic [7:0] b, input logic [7:0] exp_v, input string tag);
        exp_t e;
        @(negedge clk);
        e.val = exp_v;
        e.tag = tag;
        sb_q.push_back(e);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic desel();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk8(input logic [7:0] act, input logic [7:0] exp_v, input string tag);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp_v);
        end
    endtask

    task automatic latch_on();
        sel();
        xfer(8'h06, 8'hFF, "R11 opcode byte");
        desel();
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk8(status_o, 8'h00, "R1 status during reset");
        chk8(tx_byte, 8'hFF, "R1 tx during reset");
        rst = 1'b0;
        @(negedge clk);
        chk8(status_o, 8'h00, "R1 status after reset");
        chk8(tx_byte, 8'hFF, "R11 tx idle");

        // R3 set
        latch_on();
        chk8(status_o, 8'h02, "R3 latch set");

        // R4 status stream
        sel();
        xfer(8'h05, 8'h02, "R4 first status");
        xfer(8'h00, 8'h02, "R4 repeat status");
        xfer(8'h5A, 8'h02, "R4 repeat status");
        desel();
        chk8(tx_byte, 8'hFF, "R11 tx after frame");

        // R3 clear
        sel();
        xfer(8'h04, 8'hFF, "R11 opcode byte");
        desel();
        chk8(status_o, 8'h00, "R3 latch clear");

        // R7 write without latch
        sel();
        xfer(8'h01, 8'hFF, "R11 write opcode");
        xfer(8'hFC, 8'hFF, "R11 write data");
        desel();
        chk8(status_o, 8'h00, "R7 write blocked without latch");

        // R7 / R9 write with latch
        latch_on();
        sel();
        xfer(8'h01, 8'hFF, "R11 write opcode");
        xfer(8'h3F, 8'hFF, "R11 write data");
        @(negedge clk);
        chk8(status_o, 8'h3E, "R7 bits 7:2 loaded, low bits kept");
        desel();
        chk8(status_o, 8'h3C, "R9 latch cleared at frame end");

        // R5 JEDEC id
        sel();
        xfer(8'h9F, T_MFR,  "R5 manufacturer");
        xfer(8'h00, T_TYPE, "R5 memory type");
        xfer(8'h00, T_DEV,  "R5 device");
        xfer(8'h00, 8'hFF,  "R5 past end");
        xfer(8'h00, 8'hFF,  "R5 past end");
        desel();

        // R6 selector 0x00
        sel();
        xfer(8'h90, 8'hFF, "R6 opcode");
        xfer(8'h00, 8'hFF, "R6 dummy");
        xfer(8'h00, 8'hFF, "R6 dummy");
        xfer(8'h00, T_MFR, "R6 mfr first");
        xfer(8'h00, T_DEV, "R6 dev second");
        xfer(8'h00, 8'hFF, "R6 past end");
        desel();

        // R6 selector 0x01
        sel();
        xfer(8'h90, 8'hFF, "R6 opcode");
        xfer(8'hAA, 8'hFF, "R6 dummy");
        xfer(8'h55, 8'hFF, "R6 dummy");
        xfer(8'h01, T_DEV, "R6 dev first");
        xfer(8'h00, T_MFR, "R6 mfr second");
        xfer(8'h00, 8'hFF, "R6 past end");
        desel();

        // R11 unsupported opcode
        sel();
        xfer(8'hAB, 8'hFF, "R11 unsupported");
        xfer(8'h05, 8'hFF, "R11 unsupported body");
        xfer(8'h9F, 8'hFF, "R11 unsupported body");
        desel();

        // R12 strobes while deselected
        @(negedge clk);
        rx_byte = 8'h06; rx_valid = 1'b1;
        @(negedge clk);
        rx_byte = 8'h01; rx_valid = 1'b1;
        @(negedge clk);
        rx_byte = 8'hFF; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        chk8(status_o, 8'h3C, "R12 deselected strobes ignored");
        sel();
        xfer(8'h05, 8'h3C, "R12 frame starts at opcode");
        desel();

        // R2 / R10 busy mirror and auto clear, live status stream
        latch_on();
        busy_in = 1'b1;
        #0;
        chk8(status_o, 8'h3F, "R2 wip mirrors busy");
        sel();
        xfer(8'h05, 8'h3F, "R4 live status busy");
        @(negedge clk);
        busy_in = 1'b0;
        xfer(8'h00, 8'h3C, "R10 latch cleared by busy fall");
        desel();

        // R8 status lock
        latch_on();
        sel();
        xfer(8'h01, 8'hFF, "R11 write opcode");
        xfer(8'h80, 8'hFF, "R11 write data");
        desel();
        chk8(status_o, 8'h80, "R7 lock bit written");
        latch_on();
        sel();
        xfer(8'h01, 8'hFF, "R11 write opcode");
        xfer(8'h00, 8'hFF, "R11 write data");
        @(negedge clk);
        chk8(status_o, 8'h82, "R8 locked write blocked");
        desel();
        chk8(status_o, 8'h80, "R9 latch cleared after blocked write");
        latch_on();
        wp_in = 1'b1;
        sel();
        xfer(8'h01, 8'hFF, "R11 write opcode");
        xfer(8'h04, 8'hFF, "R11 write data");
        desel();
        wp_in = 1'b0;
        chk8(status_o, 8'h04, "R8 override permits write");

        // R1 reset mid-frame
        latch_on();
        sel();
        xfer(8'h9F, T_MFR, "R5 manufacturer");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk8(tx_byte, 8'hFF, "R1 tx after reset");
        chk8(status_o, 8'h00, "R1 status cleared");
        rst = 1'b0;
        xfer(8'h9F, T_MFR, "R1 next byte is opcode");
        xfer(8'h00, T_TYPE, "R5 memory type");
        desel();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule